// File: doc/BRIEF.md
# Debug Entry Reason Status Register

This block is the status register a debug controller uses to report why the processor core stopped. Each possible cause has its own sticky flag. The causes are a full trace buffer, a software debug instruction, five external event inputs, the event counter, the data-value comparator and address comparator 5. A cause is recorded only when its strobe arrives in the same cycle as a debug-entry or debug-exception strobe. The register also reports a fixed revision number and a fixed core-type code, both set by parameter.

The flags stay set until the core leaves debug mode, or until the user clears the debug-disable control bit (a high-to-low change on `dbg_disable`). Either event clears every flag. Software has no other way to clear them. The read port is combinational and always presents the full 24-bit register image.

Top module: `dbg_reason_status`

## Requirements
- R1: After reset every flag is 0, so `rd_data` holds only the revision and core-type fields.
- R2: `rd_data[23:21]` always equals parameter `REV_ID` and `rd_data[19:17]` always equals parameter `CORE_KIND`. No input changes either field.
- R3: Flag positions in `rd_data` are: bit 16 trace buffer full, bit 15 software debug, bits 14..10 external events 4..0, bit 9 counter, bit 8 data-value comparator, bit 5 address comparator.
- R4: A cause strobe that is high at a clock edge where `enter_dbg` or `take_exc` is also high sets its flag, visible on `rd_data` after that edge. All causes present in that cycle are set together.
- R5: A cause strobe at an edge where neither `enter_dbg` nor `take_exc` is high leaves every flag unchanged.
- R6: A set flag stays set until a clear event occurs. Later set events add flags and never remove them.
- R7: `leave_dbg` high at a clock edge clears every flag after that edge.
- R8: `dbg_disable` low at an edge after being high at the previous edge clears every flag. A rising `dbg_disable`, or one that stays high, clears nothing.
- R9: When a clear event and a set event happen at the same edge, all flags are 0 after that edge.
- R10: Bits 20, 7, 6 and 4..0 of `rd_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_full_ev | input | 1 | Trace buffer full cause strobe |
| swdbg_ev | input | 1 | Software debug instruction cause strobe |
| ext_ev | input | 5 | External event cause strobes, bit i is event i |
| cnt_ev | input | 1 | Event counter reached count |
| dval_ev | input | 1 | Data-value comparator hit |
| addr_ev | input | 1 | Address comparator 5 hit |
| enter_dbg | input | 1 | Core enters debug mode this cycle |
| take_exc | input | 1 | Core takes a debug exception this cycle |
| leave_dbg | input | 1 | Core exits debug mode this cycle |
| dbg_disable | input | 1 | Debug-disable control bit level |
| rd_data | output | 24 | Register read image |

## Verification
Each cause is first raised alone together with an entry strobe. This separates the bit positions from one another and catches any swapped or shifted flag. Causes are then raised in groups through the exception strobe, and also without any strobe. These patterns tell qualified latching apart from raw capture of the cause inputs. The clear paths are tested three ways: exit alone, a falling and a rising disable bit, and a clear that coincides with a set. This shows the flags are sticky, that the disable clear responds only to a high-to-low change, and that clear has priority. A long random phase with a behavioural model then mixes all of these patterns.

// File: rtl/dbg_reason_status.sv
module dbg_reason_status #(
  parameter logic [2:0] REV_ID    = 3'd2,
  parameter logic [2:0] CORE_KIND = 3'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trc_full_ev,
  input  logic        swdbg_ev,
  input  logic [4:0]  ext_ev,
  input  logic        cnt_ev,
  input  logic        dval_ev,
  input  logic        addr_ev,
  input  logic        enter_dbg,
  input  logic        take_exc,
  input  logic        leave_dbg,
  input  logic        dbg_disable,
  output logic [23:0] rd_data
);

  localparam int NFLAG = 10;

  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] causes;
  logic             dis_q;
  logic             trig;
  logic             clr;

  assign causes = {trc_full_ev, swdbg_ev, ext_ev, cnt_ev, dval_ev, addr_ev};
  assign trig   = enter_dbg | take_exc;
  assign clr    = leave_dbg | (dis_q & ~dbg_disable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      dis_q <= 1'b0;
    end else begin
      dis_q <= dbg_disable;
      if (clr)
        flags <= '0;
      else if (trig)
        flags <= flags | causes;
    end
  end

  assign rd_data = {REV_ID, 1'b0, CORE_KIND, flags[NFLAG-1:1], 2'b00, flags[0], 5'b00000};

  assert_set_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr) |=> ((flags & $past(causes)) == $past(causes)));

  assert_hold_without_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !clr) |=> $stable(flags));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    leave_dbg |=> (flags == '0));

  assert_dis_fall_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && !dbg_disable) |=> (flags == '0));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && trig) |=> (rd_data[16:5] == 12'd0));

endmodule

// File: tb/dbg_reason_status_tb.sv
module dbg_reason_status_tb;
  localparam logic [2:0] REV  = 3'd2;
  localparam logic [2:0] KIND = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] ev = '0;
  logic enter_dbg = 1'b0, take_exc = 1'b0, leave_dbg = 1'b0, dbg_disable = 1'b0;
  logic [23:0] rd_data;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  logic [9:0] m_flags = '0;
  logic m_dis = 1'b0;
  bit started = 0;

  always #10 clk = ~clk;

  dbg_reason_status #(.REV_ID(REV), .CORE_KIND(KIND)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .trc_full_ev(ev[9]), .swdbg_ev(ev[8]), .ext_ev(ev[7:3]),
    .cnt_ev(ev[2]), .dval_ev(ev[1]), .addr_ev(ev[0]),
    .enter_dbg(enter_dbg), .take_exc(take_exc), .leave_dbg(leave_dbg),
    .dbg_disable(dbg_disable), .rd_data(rd_data)
  );

  // behavioural reference: sticky flags, qualified set, clear wins
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0;
      m_dis = 1'b0;
    end else begin
      started = 1;
      if (leave_dbg || (m_dis && !dbg_disable)) m_flags = '0;
      else if (enter_dbg || take_exc) m_flags = m_flags | ev;
      m_dis = dbg_disable;
    end
  end

  function automatic logic [23:0] expect_img(logic [9:0] f);
    logic [23:0] v = '0;
    v[23:21] = REV;        // R2
    v[19:17] = KIND;       // R2
    v[16]    = f[9];       // R3 trace buffer
    v[15]    = f[8];       // R3 software
    v[14:10] = f[7:3];     // R3 external 4..0
    v[9]     = f[2];       // R3 counter
    v[8]     = f[1];       // R3 data value
    v[5]     = f[0];       // R3 address
    return v;
  endfunction

  always @(negedge clk) begin
    logic [23:0] e;
    e = expect_img(m_flags);
    checks++;
    if (rd_data[16:5] !== e[16:5]) begin
      errors++;
      $display("FAIL %s flags: actual=%h expected=%h", tag, rd_data, e);
    end
    checks++;
    if ({rd_data[23:17], rd_data[4:0]} !== {e[23:17], e[4:0]}) begin
      errors++;
      $display("FAIL R2/R10 fixed fields: actual=%h expected=%h", rd_data, e);
    end
  end

  task automatic step(input logic [9:0] c, input logic en, input logic ex,
                      input logic lv, input logic dis);
    @(negedge clk); #1;
    ev = c; enter_dbg = en; take_exc = ex; leave_dbg = lv; dbg_disable = dis;
  endtask

  task automatic idle(input logic dis);
    step('0, 0, 0, 0, dis);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(0); idle(0);
    tag = "R3";
    for (int i = 0; i < 10; i++) begin
      step(10'b1 << i, 1, 0, 0, 0);
      idle(0);
      step('0, 0, 0, 1, 0);
    end
    tag = "R4";
    step(10'b1010110001, 0, 1, 0, 0);
    idle(0);
    step(10'b0101001110, 1, 1, 0, 0);
    idle(0);
    step('0, 0, 0, 1, 0);
    tag = "R5";
    step(10'h3FF, 0, 0, 0, 0);
    step(10'h155, 0, 0, 0, 0);
    idle(0);
    tag = "R6";
    step(10'b0000000100, 1, 0, 0, 0);
    step(10'h3FF, 0, 0, 0, 0);
    step(10'b1000000000, 0, 1, 0, 0);
    idle(0); idle(0);
    tag = "R7";
    step('0, 0, 0, 1, 0);
    idle(0);
    tag = "R8";
    step(10'h0F0, 1, 0, 0, 1);
    idle(1); idle(1);
    step(10'h00F, 0, 1, 0, 1);
    idle(0);
    idle(0);
    step(10'h3FF, 1, 0, 0, 1);
    idle(1);
    tag = "R9";
    step(10'h3FF, 1, 0, 0, 0);
    idle(0);
    step(10'h3FF, 1, 1, 1, 0);
    idle(0);
    tag = "R10";
    for (int k = 0; k < 2000; k++) begin
      step(10'($urandom), ($urandom % 4) == 0, ($urandom % 6) == 0,
           ($urandom % 9) == 0, ($urandom % 5) != 0);
    end
    idle(0); idle(0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule